// File: doc/BRIEF.md
# VPW Bit-Arbitrating Frame Transmitter

This block sends a frame of 1 to 12 bytes onto a single-wire bus on which several nodes share the line. Each node can pull the line to the active level, and an active level from any node overrides the passive level. Every bit is one pulse, either active or passive. The length of the pulse, not its level, carries the bit value. The levels alternate from one symbol to the next. All timing is counted in pulses of a 1 µs enable input, so the system clock can be any faster rate.

The host places the bytes and the byte count on parallel inputs and pulses `start`. The transmitter waits until the line has been passive long enough to count as idle. It then drives a long active start-of-frame pulse, followed by the data symbols, most significant bit first.

While one of its own symbols is passive, the transmitter watches the received line. If another node makes the line active before the symbol's own length has run out, that node's bit was dominant. The transmitter then drops out without disturbing the winning frame, sets `lost`, and drives nothing more until the host starts it again. Any new attempt again waits for an idle line. A frame that runs to the end sets `done`.

Top module: `vpw_tx`

## Requirements
- R1: During and after reset, `bus_tx` is 0 (passive) and `busy`, `done` and `lost` are 0.
- R2: A `start` pulse is accepted only while `busy` is 0 and `frame_len` is between 1 and 12. In every other case it has no effect: a running frame keeps its own bytes and length, and an out-of-range length starts nothing.
- R3: After a start is accepted, `bus_tx` stays 0 until `bus_rx` has been 0 for 280 consecutive ticks. The start-of-frame pulse begins on the next tick after that.
- R4: The start-of-frame pulse drives `bus_tx` high for exactly 240 ticks.
- R5: Data symbols alternate between levels, and the first one after start-of-frame is passive (`bus_tx` = 0). A passive 1 and an active 0 each last 128 ticks. A passive 0 and an active 1 each last 64 ticks.
- R6: Byte k is taken from `frame_data[8k+7:8k]`. Byte 0 is sent first, and each byte is sent most significant bit first. Exactly `frame_len` bytes, that is 8·`frame_len` symbols, follow start-of-frame.
- R7: When the last symbol ends, `bus_tx` is 0, `busy` falls and `done` rises on the same tick. `done` and `lost` keep their values until the next accepted start, and they are never both 1.
- R8: If `bus_rx` is 1 on any tick during one of the block's own passive symbols, `lost` rises on that tick, `busy` falls and `bus_tx` stays 0. Against a node whose bit differs, this happens on the 65th tick of the differing symbol, whichever level that symbol has.
- R9: After a loss, `bus_tx` stays 0 while the winning frame continues. A restart issued during that frame waits the full idle time of R3, measured from the end of the winner's last active symbol.
- R10: When another node that sent identical symbols drops out because it lost at a later bit, this block completes its frame unchanged and ends with `done`.
- R11: Symbol and idle timers advance only on cycles where `tick_us` is 1, so every duration is the same number of ticks whatever the tick spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle enable pulse, once per microsecond |
| start | input | 1 | Transmit request, one cycle |
| frame_len | input | 4 | Number of bytes to send (1 to 12) |
| frame_data | input | 96 | Frame bytes; byte k in bits 8k+7:8k |
| busy | output | 1 | Request accepted, frame not yet finished |
| done | output | 1 | Last frame completed |
| lost | output | 1 | Last frame aborted on lost arbitration |
| bus_tx | output | 1 | 1 drives the line active |
| bus_rx | input | 1 | Received line level, 1 = active |

## Verification
Almost any corrupted internal state in this block shows up on `bus_tx` within one symbol. A bit or byte index that is off, or a symbol level that is flipped, changes that symbol's length from 64 to 128 ticks or back. The bench therefore decodes every run length of `bus_tx` in ticks and compares it with a symbol list it computes from the bytes. A wrong idle counter or a wrong collision check moves the start-of-frame edge or the tick of the `lost` flag. The bench measures both against closed-form tick counts, using a second modelled node that either wins or loses at a chosen bit on a passive symbol and on an active one.

// File: rtl/vpw_tx.sv
module vpw_tx #(
  parameter int MAX_BYTES = 12,
  parameter int SOF_US    = 240,
  parameter int LONG_US   = 128,
  parameter int SHORT_US  = 64,
  parameter int IDLE_US   = 280
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_us,
  input  logic                       start,
  input  logic [$clog2(MAX_BYTES+1)-1:0] frame_len,
  input  logic [MAX_BYTES*8-1:0]     frame_data,
  output logic                       busy,
  output logic                       done,
  output logic                       lost,
  output logic                       bus_tx,
  input  logic                       bus_rx
);
  localparam int LW     = $clog2(MAX_BYTES + 1);
  localparam int DW     = MAX_BYTES * 8;
  localparam int MAXSYM = (SOF_US > LONG_US) ? SOF_US : LONG_US;
  localparam int CW     = $clog2(MAXSYM);
  localparam int IW     = $clog2(IDLE_US + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SOF, S_BIT} st_t;

  st_t           st;
  logic [IW-1:0] idle_cnt;
  logic [CW-1:0] sym_cnt;
  logic [LW-1:0] byte_idx, len_q;
  logic [2:0]    bit_idx;
  logic          sym_act;
  logic [DW-1:0] data_q;
  logic          tx_q, done_q, lost_q;

  logic [7:0] cur_byte;
  logic       cur_bit, sym_end, last_bit, len_ok, bus_idle;

  assign bus_idle = idle_cnt >= IW'(IDLE_US);
  assign cur_byte = data_q[int'(byte_idx)*8 +: 8];
  assign cur_bit  = cur_byte[3'd7 - bit_idx];
  assign sym_end  = sym_cnt == ((cur_bit ^ sym_act) ? CW'(LONG_US - 1) : CW'(SHORT_US - 1));
  assign last_bit = (bit_idx == 3'd7) && (byte_idx == len_q - LW'(1));
  assign len_ok   = (frame_len != '0) && (frame_len <= LW'(MAX_BYTES));

  assign busy   = st != S_IDLE;
  assign done   = done_q;
  assign lost   = lost_q;
  assign bus_tx = tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (tick_us) begin
      if (bus_rx)         idle_cnt <= '0;
      else if (!bus_idle) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sym_cnt  <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
      len_q    <= '0;
      sym_act  <= 1'b0;
      data_q   <= '0;
      tx_q     <= 1'b0;
      done_q   <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start && len_ok) begin
          data_q <= frame_data;
          len_q  <= frame_len;
          done_q <= 1'b0;
          lost_q <= 1'b0;
          st     <= S_WAIT;
        end
        S_WAIT: if (tick_us && bus_idle) begin
          st      <= S_SOF;
          sym_cnt <= '0;
          tx_q    <= 1'b1;
        end
        S_SOF: if (tick_us) begin
          if (sym_cnt == CW'(SOF_US - 1)) begin
            st       <= S_BIT;
            sym_cnt  <= '0;
            sym_act  <= 1'b0;
            byte_idx <= '0;
            bit_idx  <= '0;
            tx_q     <= 1'b0;
          end else begin
            sym_cnt <= sym_cnt + 1'b1;
          end
        end
        S_BIT: if (tick_us) begin
          if (!sym_act && bus_rx) begin
            lost_q <= 1'b1;
            tx_q   <= 1'b0;
            st     <= S_IDLE;
          end else if (sym_end) begin
            sym_cnt <= '0;
            sym_act <= ~sym_act;
            if (last_bit) begin
              done_q <= 1'b1;
              tx_q   <= 1'b0;
              st     <= S_IDLE;
            end else begin
              tx_q    <= ~sym_act;
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == 3'd7) byte_idx <= byte_idx + 1'b1;
            end
          end else begin
            sym_cnt <= sym_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_WAIT) |-> !bus_tx);

  p_sof_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_tx) && st == S_SOF) |-> $past(bus_idle));

  p_sof_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SOF) |-> (sym_cnt < CW'(SOF_US)));

  p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!bus_tx && !busy));

  p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && lost));

  p_loss_on_dominant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> ($past(bus_rx) && !bus_tx && !busy));

  p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_us |=> $stable(bus_tx));
endmodule

// File: tb/tb_vpw_tx.sv
module tb_vpw_tx;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick_us = 1'b0, start = 1'b0;
  logic [3:0]  len = '0;
  logic [95:0] data = '0;
  logic        busy, done, lost, bus_tx, bus_rx;
  logic        oth = 1'b0;
  assign bus_rx = bus_tx | oth;

  vpw_tx dut (.clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
              .frame_len(len), .frame_data(data), .busy(busy), .done(done),
              .lost(lost), .bus_tx(bus_tx), .bus_rx(bus_rx));

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int tick_per = 1, tick_ctr = 0;
  int pas_cnt = 0, pas_at_sof = 0, s_idx = 0, lost_idx = -1;
  int run_lvl = 0, run_len = 0, nruns = 0, sof_seen = 0, tx_in_lost = 0;
  int runs [0:255];
  bit cap = 0, arb_armed = 0, play = 0, play_go = 0;
  int pl_idx = 0, pl_rem = 0, pl_n = 0;
  int pl_list [0:255];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bitv(input logic [95:0] d, input int j);
    return int'(d[(j/8)*8 + 7 - (j%8)]);
  endfunction

  function automatic int sdur(input int j, input int b);
    return ((((j%2) == 0) ? b : 1 - b) != 0) ? 128 : 64;
  endfunction

  function automatic logic [95:0] gen(input int seed);
    logic [95:0] d;
    for (int k = 0; k < 12; k++) d[k*8 +: 8] = 8'((seed*37 + k*91 + 13) ^ (k*5));
    return d;
  endfunction

  // bus monitor and second-node model, both stepped once per tick
  always @(negedge clk) begin
    if (tick_us) begin
      if (play) begin
        if (pl_rem == 1) begin
          pl_idx++;
          if (pl_idx < pl_n) begin oth = ((pl_idx % 2) == 0); pl_rem = pl_list[pl_idx]; end
          else begin oth = 1'b0; play = 0; end
        end else pl_rem--;
      end else if (play_go) begin
        play_go = 0; play = 1; pl_idx = 0; oth = 1'b1; pl_rem = pl_list[0];
      end
      if (lost && bus_tx) tx_in_lost++;
      if (!cap && bus_tx) begin
        cap = 1; sof_seen++; pas_at_sof = pas_cnt; s_idx = 0; lost_idx = -1;
        run_lvl = 1; run_len = 1; nruns = 0;
        if (arb_armed) begin
          arb_armed = 0; play = 1; pl_idx = 0; oth = 1'b1; pl_rem = pl_list[0];
        end
      end else if (cap) begin
        s_idx++;
        if (lost && lost_idx < 0) lost_idx = s_idx;
        if (done || lost) begin
          runs[nruns] = run_len; nruns++; cap = 0;
        end else if (int'(bus_tx) == run_lvl) run_len++;
        else begin
          runs[nruns] = run_len; nruns++; run_lvl = int'(bus_tx); run_len = 1;
        end
      end
      if (bus_tx | oth) pas_cnt = 0; else pas_cnt++;
    end
    tick_ctr = (tick_ctr + 1 >= tick_per) ? 0 : tick_ctr + 1;
    tick_us  = (tick_ctr == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_start(input logic [95:0] d, input int n);
    @(negedge clk);
    data = d; len = 4'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int g = 0;
    while (!((done || lost) && !cap) && g < 60000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frame(input logic [95:0] d, input int n, input string req);
    int bad = -1, exp;
    chk(nruns == 1 + 8*n, req, "symbol count", nruns, 1 + 8*n);
    chk(runs[0] == 240, "R4", "start-of-frame ticks", runs[0], 240);
    for (int j = 1; j <= 8*n && j < nruns; j++) begin
      exp = sdur(j-1, bitv(d, j-1));
      if (bad < 0 && runs[j] != exp) bad = j;
    end
    if (bad >= 0) chk(0, req, $sformatf("symbol %0d ticks", bad), runs[bad], sdur(bad-1, bitv(d, bad-1)));
    else chk(1, req, "symbols", 0, 0);
  endtask

  task automatic end_ok(input string req);
    chk(done && !lost && !busy && !bus_tx, req, "done/lost/busy/tx", {done, lost, busy, bus_tx}, 4'b1000);
  endtask

  task automatic arb_case(input int parity, input bit dut_wins, input int n, input int seed);
    logic [95:0] d = gen(seed);
    int k = -1, t_k = 240, want = dut_wins ? 0 : 1;
    for (int j = 4; j < 8*n && k < 0; j++)
      if (bitv(d, j) == want && (j % 2) == parity) k = j;
    pl_list[0] = 240;
    if (dut_wins) begin
      for (int i = 0; i < k; i++) pl_list[1+i] = sdur(i, bitv(d, i));
      pl_n = 1 + k;
      if (parity == 1) begin pl_list[1+k] = sdur(k, 1); pl_n++; end
    end else begin
      for (int i = 0; i < 8*n; i++) pl_list[1+i] = sdur(i, (i == k) ? 0 : bitv(d, i));
      pl_n = 1 + 8*n;
    end
    for (int i = 0; i < k; i++) t_k += sdur(i, bitv(d, i));
    arb_armed = 1; tx_in_lost = 0;
    do_start(d, n);
    if (dut_wins) begin
      wait_end();
      end_ok("R10");
      check_frame(d, n, "R10");
    end else begin
      for (int g = 0; g < 60000 && !lost; g++) @(negedge clk);
      @(negedge clk);
      chk(lost_idx == t_k + 65, "R8", "loss tick", lost_idx, t_k + 65);
      chk(lost && !done && !busy && !bus_tx, "R8", "status after loss", {lost, done, busy, bus_tx}, 4'b1000);
      chk(play == 1, "R9", "winner still sending", int'(play), 1);
      do_start(d, n);
      wait_end();
      chk(tx_in_lost == 0, "R9", "drive while lost", tx_in_lost, 0);
      chk(pas_at_sof == 281, "R9", "idle ticks before restart", pas_at_sof, 281);
      end_ok("R9");
      check_frame(d, n, "R6");
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_tx && !busy && !done && !lost, "R1", "in reset", {bus_tx, busy, done, lost}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_tx && !busy && !done && !lost, "R1", "after reset", {bus_tx, busy, done, lost}, 0);
    repeat (300) @(negedge clk);

    do_start(gen(1), 0);
    repeat (400) @(negedge clk);
    chk(!busy && sof_seen == 0, "R2", "length 0 ignored", sof_seen, 0);
    do_start(gen(1), 13);
    repeat (400) @(negedge clk);
    chk(!busy && sof_seen == 0, "R2", "length 13 ignored", sof_seen, 0);

    for (int n = 1; n <= 12; n++) begin
      logic [95:0] d = gen(n);
      do_start(d, n);
      if (n == 5) begin
        repeat (1500) @(negedge clk);
        do_start(gen(99), 3);
      end
      wait_end();
      end_ok("R7");
      check_frame(d, n, (n == 5) ? "R2" : "R5");
    end
    repeat (50) @(negedge clk);
    chk(done && !lost, "R7", "done held", int'(done), 1);

    do_start('0, 2);  wait_end(); check_frame('0, 2, "R5");
    do_start('1, 2);  wait_end(); check_frame('1, 2, "R6");

    tick_per = 3;
    do_start(gen(7), 2); wait_end(); end_ok("R11"); check_frame(gen(7), 2, "R11");
    tick_per = 1;

    pl_list[0] = 700; pl_n = 1;
    @(negedge clk); play_go = 1;
    repeat (3) @(negedge clk);
    do_start(gen(3), 1);
    wait_end();
    chk(pas_at_sof == 281, "R3", "idle ticks before start-of-frame", pas_at_sof, 281);
    check_frame(gen(3), 1, "R3");

    arb_case(0, 0, 3, 21);
    arb_case(1, 0, 3, 22);
    arb_case(0, 1, 3, 23);
    arb_case(1, 1, 3, 24);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule